// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This unit handles the modem-control side of one UART channel. It holds a five-bit modem control register that drives the active-low request-to-send and data-terminal-ready outputs and two general-purpose active-low outputs. It also sets the diagnostic loopback mode. The four active-low modem inputs pass through a two-flop synchronizer. The unit presents them as active-high state bits in a modem status register, together with sticky change-detect bits, and it raises a modem-status interrupt request while any change bit is set and the interrupt is enabled.

In loopback the unit reroutes the serial path and the modem signals internally. The transmit shift register output feeds the receive shift register input, and the serial output pin idles at mark. All four modem outputs go to their inactive (high) level. The modem input pins are ignored, and the status bits are fed from the control register bits instead. Every other part of the UART keeps running. Baud generation, the FIFOs and the shift registers sit outside this unit.

Top module: `uart_modem_ctl`

## Requirements
- R1: A write to address 4 stores reg_wdata[4:0] in the control register. A read of address 4 returns {3'b000, control}. Reset clears the control register to 0.
- R2: When control bit 4 is 0, the output pins follow the control bits: rts_n_pin = ~bit1, dtr_n_pin = ~bit0, out1_n_pin = ~bit2, out2_n_pin = ~bit3. tx_pin follows tsr_out, and rsr_in follows rx_pin.
- R3: When control bit 4 is 1 (loopback), tx_pin, rts_n_pin, dtr_n_pin, out1_n_pin and out2_n_pin are all 1, and rsr_in follows tsr_out regardless of rx_pin.
- R4: In loopback, the status state bits come from the control bits (CTS from bit1, DSR from bit0, RI from bit2, CD from bit3). Changes on the four modem input pins have no effect on the status register.
- R5: A read of address 6 returns the status register with CD at bit 7, RI at bit 6, DSR at bit 5 and CTS at bit 4. Each state bit is the complement of its active-low pin and becomes visible after the third rising clock edge following a pin change.
- R6: Change bits sit at bit 3 (CD), bit 2 (RI), bit 1 (DSR) and bit 0 (CTS). The CD, DSR and CTS change bits set on any change of their state. The RI change bit sets only when the RI state falls from 1 to 0.
- R7: A status read returns the value held before the read and clears all change bits at that clock edge. A change detected at the same edge as the read leaves its change bit set.
- R8: msr_irq is 1 exactly while msi_enable is 1 and at least one change bit is set.
- R9: Writing control bit 4 back to 0 restores the pin connections from the next clock, and the other stored control bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| msi_enable | input | 1 | Modem-status interrupt enable (bit 3 of the interrupt enable register) |
| tsr_out | input | 1 | Serial output of the transmit shift register |
| rsr_in | output | 1 | Serial input to the receive shift register |
| tx_pin | output | 1 | Serial output pin |
| rx_pin | input | 1 | Serial input pin |
| rts_n_pin | output | 1 | Request to send, active low |
| dtr_n_pin | output | 1 | Data terminal ready, active low |
| out1_n_pin | output | 1 | General-purpose output 1, active low |
| out2_n_pin | output | 1 | General-purpose output 2, active low |
| cts_n_pin | input | 1 | Clear to send, active low |
| dsr_n_pin | input | 1 | Data set ready, active low |
| dcd_n_pin | input | 1 | Carrier detect, active low |
| ri_n_pin | input | 1 | Ring indicator, active low |
| msr_irq | output | 1 | Modem-status interrupt request |

## Verification
A status read and a newly detected input change can land on the same clock edge. In that case the read must return the old change bit, and the new change bit must survive the clear. The bench provokes this by switching the DSR pin and counting two synchronizer edges. It then holds the read strobe across the third edge, the one at which the change registers. It checks that the read data shows the DSR change bit as 0 and that the bit reads as 1 after that edge. Entering and leaving loopback also changes the status source at the edge of the control write, and the bench checks the change bits that follow from this.

// File: rtl/uart_modem_pkg.sv
// Package: shared constants and types for the modem control unit.
// Assumes a three-bit register address space local to one channel.
package uart_modem_pkg;
    localparam int        DATA_W   = 8;
    localparam int        ADDR_W   = 3;
    localparam int        CTRL_W   = 5;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd4;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd6;

    // control register bit positions
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    localparam int C_LOOP = 4;

    // active-high modem line states, packed in status register order
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;
endpackage

// File: rtl/modem_sync.sv
// Module: multi-stage synchronizer for asynchronous modem input pins.
// Assumes each bit is independent; reset loads RST_VAL into every stage.
module modem_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // shift the pin values through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/modem_loop_mux.sv
// Module: steers the serial path and the modem lines between the pins and
// the internal loopback wiring. Purely combinational; assumes ctrl is registered.
module modem_loop_mux
    import uart_modem_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              tsr_out,
    input  logic              rx_pin,
    input  mdm_lines_t        ext_lines,
    output logic              tx_pin,
    output logic              rsr_in,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              out1_n,
    output logic              out2_n,
    output mdm_lines_t        lines
);
    logic loop_on;
    assign loop_on = ctrl[C_LOOP];

    // serial path: wrap transmit into receive and park the pin at mark
    always_comb begin
        tx_pin = loop_on ? 1'b1 : tsr_out;
        rsr_in = loop_on ? tsr_out : rx_pin;
    end

    // outputs go inactive (high) during loopback
    always_comb begin
        rts_n  = loop_on | ~ctrl[C_RTS];
        dtr_n  = loop_on | ~ctrl[C_DTR];
        out1_n = loop_on | ~ctrl[C_OUT1];
        out2_n = loop_on | ~ctrl[C_OUT2];
    end

    // status source: control bits in loopback, synchronized pins otherwise
    always_comb begin
        if (loop_on) begin
            lines.cts = ctrl[C_RTS];
            lines.dsr = ctrl[C_DTR];
            lines.ri  = ctrl[C_OUT1];
            lines.cd  = ctrl[C_OUT2];
        end else begin
            lines = ext_lines;
        end
    end
endmodule

// File: rtl/modem_status.sv
// Module: modem status register with sticky change bits and interrupt request.
// Assumes src is already synchronous; a read clears changes, but a new one wins.
module modem_status
    import uart_modem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mdm_lines_t src,
    input  logic       rd_clr,
    input  logic       irq_en,
    output logic [DATA_W-1:0] status,
    output logic       irq
);
    mdm_lines_t state_q;
    mdm_lines_t delta_q;
    mdm_lines_t hit;

    // change events this cycle; RI only on the end of a ring
    always_comb begin
        hit.cts = src.cts ^ state_q.cts;
        hit.dsr = src.dsr ^ state_q.dsr;
        hit.cd  = src.cd  ^ state_q.cd;
        hit.ri  = state_q.ri & ~src.ri;
    end

    // register the line state and accumulate the change bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            delta_q <= '0;
        end else begin
            state_q <= src;
            delta_q <= (rd_clr ? '0 : delta_q) | hit;
        end
    end

    assign status = {state_q, delta_q};
    assign irq    = irq_en & (|delta_q);

    AST_RI_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q.ri) |-> $fell(state_q.ri)); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && src == state_q) |=> delta_q == '0); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en); // R8
endmodule

// File: rtl/uart_modem_ctl.sv
// Module: modem control unit for one UART channel. It holds the control
// register, synchronizes the modem pins, applies loopback and keeps the status register.
// Assumes single-cycle register strobes and combinational read data.
module uart_modem_ctl
    import uart_modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              msi_enable,
    input  logic              tsr_out,
    output logic              rsr_in,
    output logic              tx_pin,
    input  logic              rx_pin,
    output logic              rts_n_pin,
    output logic              dtr_n_pin,
    output logic              out1_n_pin,
    output logic              out2_n_pin,
    input  logic              cts_n_pin,
    input  logic              dsr_n_pin,
    input  logic              dcd_n_pin,
    input  logic              ri_n_pin,
    output logic              msr_irq
);
    localparam int N_LINES = $bits(mdm_lines_t);

    logic [CTRL_W-1:0]  ctrl_q;
    logic [N_LINES-1:0] pins_sync;
    mdm_lines_t         ext_lines;
    mdm_lines_t         lines;
    logic [DATA_W-1:0]  status;
    logic               wr_ctrl;
    logic               rd_stat;
    logic               unused_wbits;

    assign wr_ctrl      = reg_wr && (reg_addr == CTRL_ADDR);
    assign rd_stat      = reg_rd && (reg_addr == STAT_ADDR);
    assign unused_wbits = ^reg_wdata[DATA_W-1:CTRL_W];

    // control register write
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    modem_sync #(.WIDTH(N_LINES), .STAGES(2), .RST_VAL('1)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dcd_n_pin, ri_n_pin, dsr_n_pin, cts_n_pin}),
        .sync_out (pins_sync)
    );

    assign ext_lines = mdm_lines_t'(~pins_sync);

    modem_loop_mux i_mux (
        .ctrl      (ctrl_q),
        .tsr_out   (tsr_out),
        .rx_pin    (rx_pin),
        .ext_lines (ext_lines),
        .tx_pin    (tx_pin),
        .rsr_in    (rsr_in),
        .rts_n     (rts_n_pin),
        .dtr_n     (dtr_n_pin),
        .out1_n    (out1_n_pin),
        .out2_n    (out2_n_pin),
        .lines     (lines)
    );

    modem_status i_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (lines),
        .rd_clr (rd_stat),
        .irq_en (msi_enable),
        .status (status),
        .irq    (msr_irq)
    );

    // read data select
    always_comb begin
        unique case (reg_addr)
            CTRL_ADDR: reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            STAT_ADDR: reg_rdata = status;
            default:   reg_rdata = '0;
        endcase
    end

    AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ctrl_q == $past(reg_wdata[CTRL_W-1:0])); // R1
    AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[C_LOOP] |-> (tx_pin && rts_n_pin && dtr_n_pin && out1_n_pin && out2_n_pin)); // R3
    AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[C_LOOP] |-> (rsr_in == tsr_out)); // R3
    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q)); // R9
endmodule

// File: tb/test_uart_modem_ctl.sv
module test_uart_modem_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       msi_enable = 1'b0;
    logic       tsr_out = 1'b1, rx_pin = 1'b1;
    logic       rsr_in, tx_pin, rts_n_pin, dtr_n_pin, out1_n_pin, out2_n_pin, msr_irq;
    logic       cts_n_pin = 1'b1, dsr_n_pin = 1'b1, dcd_n_pin = 1'b1, ri_n_pin = 1'b1;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    uart_modem_ctl i_uart_modem_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msi_enable(msi_enable), .tsr_out(tsr_out), .rsr_in(rsr_in),
        .tx_pin(tx_pin), .rx_pin(rx_pin), .rts_n_pin(rts_n_pin),
        .dtr_n_pin(dtr_n_pin), .out1_n_pin(out1_n_pin), .out2_n_pin(out2_n_pin),
        .cts_n_pin(cts_n_pin), .dsr_n_pin(dsr_n_pin), .dcd_n_pin(dcd_n_pin),
        .ri_n_pin(ri_n_pin), .msr_irq(msr_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // reads without clearing (address 4) or with clearing (address 6); result at negedge
    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek_stat(output logic [7:0] d);
        reg_addr = 3'd6;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 reset pins", {4'h0, rts_n_pin, dtr_n_pin, out1_n_pin, out2_n_pin}, 8'h0F);
        check("R8 reset irq", {7'h0, msr_irq}, 8'h00);
        rd_reg(3'd4, d); check("R1 reset ctrl", d, 8'h00);
        rd_reg(3'd6, d); check("R5 reset status", d, 8'h00);
    endtask

    task automatic t_ctrl_pins();
        logic [7:0] d;
        wr_ctrl(8'hEB);
        rd_reg(3'd4, d); check("R1 ctrl readback", d, 8'h0B);
        check("R2 pins", {4'h0, rts_n_pin, dtr_n_pin, out1_n_pin, out2_n_pin}, 8'h02);
        tsr_out = 1'b0; rx_pin = 1'b1; #1;
        check("R2 tx follows", {7'h0, tx_pin}, 8'h00);
        check("R2 rx follows", {7'h0, rsr_in}, 8'h01);
        tsr_out = 1'b1; rx_pin = 1'b0; #1;
        check("R2 tx/rx swap", {6'h0, tx_pin, rsr_in}, 8'h02);
        rx_pin = 1'b1;
    endtask

    task automatic t_pin_status();
        logic [7:0] d;
        @(negedge clk); cts_n_pin = 1'b0;
        wait_edges(2); peek_stat(d); check("R5 not yet after 2 edges", d, 8'h00);
        wait_edges(1); peek_stat(d); check("R5 R6 cts state and change", d, 8'h11);
        msi_enable = 1'b1; #1; check("R8 irq on", {7'h0, msr_irq}, 8'h01);
        msi_enable = 1'b0; #1; check("R8 irq gated", {7'h0, msr_irq}, 8'h00);
        msi_enable = 1'b1;
        rd_reg(3'd6, d); check("R7 read returns old", d, 8'h11);
        peek_stat(d); check("R7 change cleared", d, 8'h10);
        check("R8 irq off", {7'h0, msr_irq}, 8'h00);
        @(negedge clk); cts_n_pin = 1'b1; wait_edges(3);
        rd_reg(3'd6, d); check("R6 cts release change", d, 8'h01);
    endtask

    task automatic t_ring();
        logic [7:0] d;
        @(negedge clk); ri_n_pin = 1'b0; wait_edges(3);
        peek_stat(d); check("R6 ring start no change", d, 8'h40);
        @(negedge clk); ri_n_pin = 1'b1; wait_edges(3);
        peek_stat(d); check("R6 ring end change", d, 8'h04);
        rd_reg(3'd6, d);
        @(negedge clk); dcd_n_pin = 1'b0; wait_edges(3);
        rd_reg(3'd6, d); check("R5 R6 cd bit", d, 8'h88);
        @(negedge clk); dcd_n_pin = 1'b1; wait_edges(3);
        rd_reg(3'd6, d);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        @(negedge clk); dsr_n_pin = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd6;
        #1 check("R7 read before change", reg_rdata & 8'h02, 8'h00);
        @(posedge clk); @(negedge clk); reg_rd = 1'b0;
        peek_stat(d); check("R7 change survives read", d, 8'h22);
        @(negedge clk); dsr_n_pin = 1'b1; wait_edges(3);
        rd_reg(3'd6, d);
    endtask

    task automatic t_loop();
        logic [7:0] d;
        rd_reg(3'd6, d);
        wr_ctrl(8'h10);
        check("R3 pins idle", {3'h0, tx_pin, rts_n_pin, dtr_n_pin, out1_n_pin, out2_n_pin}, 8'h1F);
        tsr_out = 1'b0; rx_pin = 1'b1; #1;
        check("R3 wrap low", {6'h0, tx_pin, rsr_in}, 8'h02);
        tsr_out = 1'b1; rx_pin = 1'b0; #1;
        check("R3 wrap high", {6'h0, tx_pin, rsr_in}, 8'h03);
        rx_pin = 1'b1;
        wr_ctrl(8'h1F);
        check("R3 pins idle all set", {4'h0, rts_n_pin, dtr_n_pin, out1_n_pin, out2_n_pin}, 8'h0F);
        wait_edges(1);
        rd_reg(3'd6, d); check("R4 status from ctrl", d, 8'hFB);
        @(negedge clk); cts_n_pin = 1'b0; dsr_n_pin = 1'b0; ri_n_pin = 1'b0; dcd_n_pin = 1'b0;
        wait_edges(4);
        peek_stat(d); check("R4 pins ignored", d, 8'hF0);
        @(negedge clk); cts_n_pin = 1'b1; dsr_n_pin = 1'b1; ri_n_pin = 1'b1; dcd_n_pin = 1'b1;
        wait_edges(4);
        peek_stat(d); check("R4 pins ignored again", d, 8'hF0);
        wr_ctrl(8'h13);
        wait_edges(1);
        rd_reg(3'd6, d); check("R4 RI and CD drop", d, 8'h3C);
    endtask

    task automatic t_exit();
        logic [7:0] d;
        wr_ctrl(8'h03);
        check("R9 pins restored", {4'h0, rts_n_pin, dtr_n_pin, out1_n_pin, out2_n_pin}, 8'h03);
        tsr_out = 1'b0; rx_pin = 1'b1; #1;
        check("R9 serial restored", {6'h0, tx_pin, rsr_in}, 8'h01);
        tsr_out = 1'b1;
        rd_reg(3'd4, d); check("R9 ctrl kept", d, 8'h03);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_ctrl_pins();
        t_pin_status();
        t_ring();
        t_same_cycle();
        t_loop();
        t_exit();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule